// File: doc/BRIEF.md
# Truncated Timestamp Seconds Extender

An event timestamp is often captured with only a small slice of the seconds count, because a descriptor has little room for it. This block turns such a short timestamp back into a full 48-bit seconds value and a 30-bit nanoseconds value. It reads two 32-bit descriptor words. The first word carries the nanoseconds and the low part of the short seconds field. The second word carries the high part of that field and a flag that says whether a capture took place. The block joins the two parts of the short seconds field. It takes the upper seconds bits from the live time-of-day seconds count, which is presented alongside the words.

The block assumes the descriptor is read back well within one period of the short seconds field after the capture. Under that assumption, a half-range test finds the one case where the live count has moved into a new period since the capture, and the block takes one full period off the result. The result is registered. It appears one cycle after an accepted input, together with a matching valid pulse.

Top module: `ts_seconds_extender`

## Requirements
- R1: Descriptor layout: word one bits [29:0] hold the nanoseconds and bits [31:30] hold the low 2 bits of the short seconds field. Word two bits [3:0] hold the high 4 bits of that field, and bit 31 is the capture flag. Word two bits [30:4] are reserved and have no effect on the result.
- R2: The short seconds field is the 6-bit value {word two [3:0], word one [31:30]}. Bits [5:0] of the output seconds always equal this value.
- R3: When no wrap is detected, the output seconds equal the live seconds with bits [5:0] cleared, plus the short seconds field.
- R4: A wrap is detected when bit 5 of the short field is 1 and bit 5 of the live seconds is 0. In that case the result of R3 is reduced by 64, modulo 2^48.
- R5: When bit 5 of the short field is 0, no correction is applied, whatever the value of bit 5 of the live seconds.
- R6: An input accepted in one cycle (input valid high and capture flag set) produces output valid high in the next cycle, carrying that input's result.
- R7: When input valid is low, or the capture flag is clear, output valid is low in the next cycle and the seconds and nanoseconds outputs keep their previous values.
- R8: While reset is high, output valid, output seconds and output nanoseconds are all driven to zero from the next clock edge.
- R9: The output nanoseconds equal word one bits [29:0] of the accepted input, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor words and live seconds are present |
| in_word_a | input | 32 | Descriptor word one: nanoseconds and low short-seconds bits |
| in_word_b | input | 32 | Descriptor word two: high short-seconds bits and capture flag |
| in_tod_sec | input | 48 | Live time-of-day seconds |
| out_valid | output | 1 | Registered result valid |
| out_sec | output | 48 | Rebuilt full seconds |
| out_ns | output | 30 | Nanoseconds of the event |

## Verification
The bench works through all four combinations of the two bit-5 values. A design that compares the wrong bit, or inverts the test, moves the result by 64 seconds in exactly one of these cases. It also covers a wrap when the live upper seconds are zero, which must wrap the result to the top of the 48-bit range, and a wrap when the live count sits on a 2^47 boundary, which must borrow across many bits. A design that joins the two slices in the wrong order, or at the wrong offset, produces wrong low seconds bits. The bench checks that reserved descriptor bits have no effect. It also checks that a cleared capture flag neither raises valid nor changes the held outputs; a design that gates on valid alone would emit a spurious result.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  // Correction applied to the rebuilt seconds value
  typedef enum logic [0:0] {
    CORR_NONE = 1'b0,
    CORR_WRAP = 1'b1
  } tsx_corr_e;
endpackage

// File: rtl/tsx_field_split.sv
module tsx_field_split #(
  parameter int WORD_W   = 32,
  parameter int NS_W     = 30,
  parameter int SLO_W    = 2,
  parameter int SHI_W    = 4,
  parameter int FLAG_POS = 31
) (
  input  logic [WORD_W-1:0]      word_a,
  input  logic [WORD_W-1:0]      word_b,
  output logic [NS_W-1:0]        ns,
  output logic [SLO_W+SHI_W-1:0] trunc_sec,
  output logic                   cap_flag
);
  localparam int TW = SLO_W + SHI_W;

  logic [SLO_W-1:0] sec_lo;
  logic [SHI_W-1:0] sec_hi;

  always_comb begin
    ns        = word_a[NS_W-1:0];
    sec_lo    = word_a[NS_W +: SLO_W];
    sec_hi    = word_b[SHI_W-1:0];
    cap_flag  = word_b[FLAG_POS];
    trunc_sec = TW'({sec_hi, sec_lo});
  end
endmodule

// File: rtl/tsx_wrap_fix.sv
module tsx_wrap_fix
  import tsx_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int TW    = 6
) (
  input  logic [TW-1:0]    trunc_sec,
  input  logic [SEC_W-1:0] tod_sec,
  output logic [SEC_W-1:0] full_sec,
  output tsx_corr_e        corr
);
  localparam logic [SEC_W-1:0] LOW_MASK = {{(SEC_W-TW){1'b0}}, {TW{1'b1}}};
  localparam logic [SEC_W-1:0] RANGE    = {{(SEC_W-TW-1){1'b0}}, 1'b1, {TW{1'b0}}};

  logic [SEC_W-1:0] base;
  logic [SEC_W-1:0] merged;

  always_comb begin
    corr   = (trunc_sec[TW-1] && !tod_sec[TW-1]) ? CORR_WRAP : CORR_NONE;
    base   = tod_sec & ~LOW_MASK;
    merged = base + {{(SEC_W-TW){1'b0}}, trunc_sec};
    if (corr == CORR_WRAP) full_sec = merged - RANGE;
    else                   full_sec = merged;
  end
endmodule

// File: rtl/ts_seconds_extender.sv
module ts_seconds_extender
  import tsx_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NS_W     = 30,
  parameter int SLO_W    = 2,
  parameter int SHI_W    = 4,
  parameter int SEC_W    = 48,
  parameter int FLAG_POS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word_a,
  input  logic [WORD_W-1:0] in_word_b,
  input  logic [SEC_W-1:0]  in_tod_sec,
  output logic              out_valid,
  output logic [SEC_W-1:0]  out_sec,
  output logic [NS_W-1:0]   out_ns
);
  localparam int TW = SLO_W + SHI_W;

  logic [NS_W-1:0]  ns_w;
  logic [TW-1:0]    trunc_w;
  logic             flag_w;
  logic [SEC_W-1:0] sec_w;
  tsx_corr_e        corr_w;
  logic             accept;

  tsx_field_split #(
    .WORD_W(WORD_W), .NS_W(NS_W), .SLO_W(SLO_W), .SHI_W(SHI_W), .FLAG_POS(FLAG_POS)
  ) split_i (
    .word_a(in_word_a), .word_b(in_word_b),
    .ns(ns_w), .trunc_sec(trunc_w), .cap_flag(flag_w)
  );

  tsx_wrap_fix #(.SEC_W(SEC_W), .TW(TW)) fix_i (
    .trunc_sec(trunc_w), .tod_sec(in_tod_sec),
    .full_sec(sec_w), .corr(corr_w)
  );

  assign accept = in_valid && flag_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sec   <= '0;
      out_ns    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_sec <= sec_w;
        out_ns  <= ns_w;
      end
    end
  end

  // R6: an accepted input yields a valid result next cycle
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word_b[FLAG_POS]) |=> out_valid);

  // R7: no output when not accepted, and held values
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_word_b[FLAG_POS]) |=> (!out_valid && $stable(out_sec) && $stable(out_ns)));

  // R9: nanoseconds pass through
  p_ns_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word_b[FLAG_POS]) |=> out_ns == $past(in_word_a[NS_W-1:0]));

  // R2: low seconds bits match the short field
  p_low_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word_b[FLAG_POS]) |=>
      out_sec[TW-1:0] == $past({in_word_b[SHI_W-1:0], in_word_a[NS_W +: SLO_W]}));

  // R4: correction only when short top bit set and live top bit clear
  p_wrap_cond_r4: assert property (@(posedge clk) disable iff (rst)
    (corr_w == CORR_WRAP) |-> (trunc_w[TW-1] && !in_tod_sec[TW-1]));

  // R5: short top bit clear never corrects
  p_no_corr_r5: assert property (@(posedge clk) disable iff (rst)
    !in_word_b[SHI_W-1] |-> (sec_w[SEC_W-1:TW] == in_tod_sec[SEC_W-1:TW]));
endmodule

// File: tb/ts_seconds_extender_tb_top.sv
module ts_seconds_extender_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word_a, in_word_b;
  logic [47:0] in_tod_sec;
  logic        out_valid;
  logic [47:0] out_sec;
  logic [29:0] out_ns;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ts_seconds_extender dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_word_a(in_word_a), .in_word_b(in_word_b), .in_tod_sec(in_tod_sec),
    .out_valid(out_valid), .out_sec(out_sec), .out_ns(out_ns)
  );

  typedef struct packed {
    logic [31:0] wa;
    logic [31:0] wb;
    logic [47:0] tod;
    logic [47:0] exp_sec;
    logic [29:0] exp_ns;
  } vec_t;

  // word a = {lo[1:0], ns[29:0]}; word b = {flag, reserved[26:0], hi[3:0]}
  localparam vec_t VECS [6] = '{
    // R3/R5: short bit5=0, live bit5=1
    '{ {2'b01, 30'd123456789}, {1'b1, 27'd0, 4'b0010}, 48'h0000_1234_5678,
       48'h0000_1234_5649, 30'd123456789 },
    // R4: wrap, short 35, live low 0
    '{ {2'b11, 30'd999999999}, {1'b1, 27'h5A5A5A5, 4'b1000}, 48'h0000_0000_1000,
       48'h0000_0000_0FE3, 30'd999999999 },
    // R3: both bit5 set, no wrap
    '{ {2'b11, 30'd0}, {1'b1, 27'd0, 4'b1111}, 48'h0000_ABCD_EF3F,
       48'h0000_ABCD_EF3F, 30'd0 },
    // R5: both bit5 clear
    '{ {2'b00, 30'd500000000}, {1'b1, 27'h7FFFFFF, 4'b0000}, 48'hFFFF_FFFF_FF80,
       48'hFFFF_FFFF_FF80, 30'd500000000 },
    // R4: wrap with zero upper bits underflows
    '{ {2'b00, 30'd1}, {1'b1, 27'd0, 4'b1000}, 48'h0000_0000_0000,
       48'hFFFF_FFFF_FFE0, 30'd1 },
    // R4: wrap borrowing across bit 47
    '{ {2'b01, 30'd42}, {1'b1, 27'd0, 4'b1001}, 48'h8000_0000_0015,
       48'h7FFF_FFFF_FFE5, 30'd42 }
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    in_word_a = '0; in_word_b = '0; in_tod_sec = '0;
    repeat (3) @(negedge clk);
    chk("R8 valid", 64'(out_valid), 64'd0);
    chk("R8 sec", 64'(out_sec), 64'd0);
    chk("R8 ns", 64'(out_ns), 64'd0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R9
    foreach (VECS[i]) begin
      @(negedge clk);
      in_valid = 1'b1; in_word_a = VECS[i].wa; in_word_b = VECS[i].wb;
      in_tod_sec = VECS[i].tod;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R6 valid v%0d", i), 64'(out_valid), 64'd1);
      chk($sformatf("R3/R4/R5 sec v%0d", i), 64'(out_sec), 64'(VECS[i].exp_sec));
      chk($sformatf("R9 ns v%0d", i), 64'(out_ns), 64'(VECS[i].exp_ns));
      chk($sformatf("R2 low bits v%0d", i), 64'(out_sec[5:0]),
          64'({VECS[i].wb[3:0], VECS[i].wa[31:30]}));
    end

    // R7: valid high but capture flag clear -> nothing, outputs held
    @(negedge clk);
    chk("R7 idle valid", 64'(out_valid), 64'd0);
    in_valid = 1'b1; in_word_a = {2'b10, 30'd77}; in_word_b = {1'b0, 27'd0, 4'b0101};
    in_tod_sec = 48'h1111_2222_3333;
    @(negedge clk);
    chk("R7 flag clear valid", 64'(out_valid), 64'd0);
    chk("R7 flag clear sec held", 64'(out_sec), 64'h7FFF_FFFF_FFE5);
    chk("R7 flag clear ns held", 64'(out_ns), 64'd42);

    // R7: flag set but valid low
    in_valid = 1'b0; in_word_b = {1'b1, 27'd0, 4'b0101};
    @(negedge clk);
    chk("R7 valid low", 64'(out_valid), 64'd0);
    chk("R7 valid low sec held", 64'(out_sec), 64'h7FFF_FFFF_FFE5);

    // R1: reserved bits of word b do not change the result
    in_valid = 1'b1; in_word_a = {2'b10, 30'd77};
    in_word_b = {1'b1, 27'h1234567, 4'b0101}; in_tod_sec = 48'h1111_2222_3333;
    @(negedge clk);
    in_valid = 1'b0;
    // short = {0101,10} = 22, live low6 = 0x33, base 0x111122223300
    chk("R1 reserved ignored sec", 64'(out_sec), 64'h1111_2222_3316);
    chk("R1 ns field", 64'(out_ns), 64'd77);

    // R6: back-to-back accepted inputs
    in_valid = 1'b1; in_word_a = {2'b00, 30'd5}; in_word_b = {1'b1, 27'd0, 4'b0000};
    in_tod_sec = 48'h0000_0000_0100;
    @(negedge clk);
    chk("R6 b2b first", 64'(out_sec), 64'h100);
    in_word_a = {2'b11, 30'd6}; in_word_b = {1'b1, 27'd0, 4'b1111};
    in_tod_sec = 48'h0000_0000_0140; // bit5 0, short 63 -> wrap
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 b2b second valid", 64'(out_valid), 64'd1);
    chk("R4 b2b second sec", 64'(out_sec), 64'h13F);

    // R8: reset clears registered outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset valid", 64'(out_valid), 64'd0);
    chk("R8 mid reset sec", 64'(out_sec), 64'd0);
    chk("R8 mid reset ns", 64'(out_ns), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule